// File: doc/BRIEF.md
# Audio FIFO Event and Interrupt Status Unit

This unit sits beside a transmit/receive audio FIFO pair. It watches the FIFO fill levels and the event strobes that the FIFO logic raises, and records each event in a sticky status bit. An enable mask selects which status bits may raise the single interrupt line. Software reads the status word and acknowledges events by writing ones back to the bits it has handled. The unit also holds the two level thresholds and reports the number of entries available on each side.

There are four word-wide registers behind a two-bit address. Address 0 holds the thresholds. Address 1 is the status word. Address 2 is the interrupt enable. Address 3 reports the counts and is read-only. Reads are combinational from the address. Writes take effect at the clock edge on which `regWrEn` is high.

Top module: `fifo_evt_irq`

## Requirements
- R1: After reset the configuration word (address 0) reads 0x4040, meaning both thresholds are 4. The status and enable words read 0 and `irq` is low.
- R2: A transmit event strobe that is high at a clock edge sets its status bit at that edge: underrun sets bit 1, overrun sets bit 2, fault sets bit 3. The bit stays set after the strobe drops.
- R3: A receive event strobe sets its status bit in the same way: underrun sets bit 5, overrun sets bit 6, fault sets bit 7. The bit is sticky.
- R4: Status bit 0 is set at the edge where `txLevel < txThreshold` first becomes true. While the level stays below the threshold it does not set the bit again.
- R5: Status bit 4 is set at the edge where `rxLevel >= rxThreshold` first becomes true. It does not set again while that condition persists.
- R6: Writing the status address clears every status bit whose written data bit is 1. Status bits whose data bit is 0 keep their value.
- R7: When an event and a clearing write hit the same status bit at the same edge, the bit ends up set.
- R8: `irq` is high exactly when the status word ANDed with the enable word is nonzero. Writing 0 to the enable word forces `irq` low.
- R9: The configuration word holds the receive threshold in bits 15..12 and the transmit threshold in bits 7..4. All other bits read 0.
- R10: The count word (address 3) reads the transmit free count in bits 3..0, equal to 15 minus `txLevel` and floored at 0. It reads `rxLevel` in bits 7..4 and 0 in the other bits. Writes to address 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txLevel | input | 4 | Transmit FIFO fill level |
| rxLevel | input | 4 | Receive FIFO fill level |
| txUnderrun | input | 1 | Transmit underrun strobe |
| txOverrun | input | 1 | Transmit overrun strobe |
| txFault | input | 1 | Transmit transfer fault strobe |
| rxUnderrun | input | 1 | Receive underrun strobe |
| rxOverrun | input | 1 | Receive overrun strobe |
| rxFault | input | 1 | Receive transfer fault strobe |
| regAddr | input | 2 | Register address |
| regWrEn | input | 1 | Register write enable |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
Event strobes, level crossings, clearing writes and enable writes all act on the next rising edge. The status word and `irq` therefore show the result one edge after the stimulus, while count reads follow the levels in the same cycle. The bench applies every stimulus at a falling edge and reads back at the following falling edge. This places each check exactly one rising edge after its cause. Threshold crossings are swept over every threshold and level pair, and the interrupt mask over all 256 enable values.

// File: rtl/fifo_evt_irq_pkg.sv
package fifo_evt_irq_pkg;
  localparam int ADDR_W     = 2;
  localparam int STAT_W     = 8;
  localparam int TX_THR_LSB = 4;
  localparam int RX_THR_LSB = 12;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CFG  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_EN   = 2'd2,
    SEL_CNT  = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgWr;
    logic statClr;
    logic enWr;
  } regStrobe_t;
endpackage

// File: rtl/fifo_evt_irq_ctrl.sv
module fifo_evt_irq_ctrl
  import fifo_evt_irq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] cfgWord,
  input  logic [DATA_W-1:0] statusWord,
  input  logic [DATA_W-1:0] enableWord,
  input  logic [DATA_W-1:0] countWord,
  output regStrobe_t        stb,
  output logic [DATA_W-1:0] regRdData
);
  regSel_e sel;
  assign sel = regSel_e'(regAddr);

  always_comb begin
    stb = '0;
    if (regWrEn) begin
      unique case (sel)
        SEL_CFG:  stb.cfgWr   = 1'b1;
        SEL_STAT: stb.statClr = 1'b1;
        SEL_EN:   stb.enWr    = 1'b1;
        default:  ;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CFG:  regRdData = cfgWord;
      SEL_STAT: regRdData = statusWord;
      SEL_EN:   regRdData = enableWord;
      default:  regRdData = countWord;
    endcase
  end
endmodule

// File: rtl/fifo_evt_irq_dp.sv
module fifo_evt_irq_dp
  import fifo_evt_irq_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int FIFO_DEPTH = 15,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  txLevel,
  input  logic [CNT_W-1:0]  rxLevel,
  input  logic              txUnderrun,
  input  logic              txOverrun,
  input  logic              txFault,
  input  logic              rxUnderrun,
  input  logic              rxOverrun,
  input  logic              rxFault,
  input  regStrobe_t        stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] cfgWord,
  output logic [DATA_W-1:0] statusWord,
  output logic [DATA_W-1:0] enableWord,
  output logic [DATA_W-1:0] countWord,
  output logic              irq
);
  localparam logic [CNT_W-1:0] THR_RESET = CNT_W'(4);
  localparam logic [CNT_W-1:0] DEPTH_V   = CNT_W'(FIFO_DEPTH);

  logic [CNT_W-1:0]  thrTxQ, thrRxQ;
  logic [STAT_W-1:0] statusQ, enableQ;
  logic              txBelowQ, rxAtQ;
  logic              txBelowNow, rxAtNow;
  logic [STAT_W-1:0] evtVec, clrVec;
  logic [CNT_W-1:0]  txFree;

  // threshold registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrTxQ <= THR_RESET;
      thrRxQ <= THR_RESET;
    end else if (stb.cfgWr) begin
      thrTxQ <= wrData[TX_THR_LSB +: CNT_W];
      thrRxQ <= wrData[RX_THR_LSB +: CNT_W];
    end
  end

  // enable mask
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         enableQ <= '0;
    else if (stb.enWr) enableQ <= wrData[STAT_W-1:0];
  end

  // crossing detectors; history starts "already on that side"
  assign txBelowNow = (txLevel < thrTxQ);
  assign rxAtNow    = (rxLevel >= thrRxQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBelowQ <= 1'b1;
      rxAtQ    <= 1'b1;
    end else begin
      txBelowQ <= txBelowNow;
      rxAtQ    <= rxAtNow;
    end
  end

  assign evtVec = {rxFault, rxOverrun, rxUnderrun, rxAtNow & ~rxAtQ,
                   txFault, txOverrun, txUnderrun, txBelowNow & ~txBelowQ};
  assign clrVec = stb.statClr ? wrData[STAT_W-1:0] : '0;

  // one sticky bit per event; set dominates clear
  for (genvar b = 0; b < STAT_W; b++) begin : g_stat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          statusQ[b] <= 1'b0;
      else if (evtVec[b]) statusQ[b] <= 1'b1;
      else if (clrVec[b]) statusQ[b] <= 1'b0;
    end
  end

  assign irq = |(statusQ & enableQ);

  assign txFree = (txLevel >= DEPTH_V) ? '0 : DEPTH_V - txLevel;

  always_comb begin
    cfgWord = '0;
    cfgWord[TX_THR_LSB +: CNT_W] = thrTxQ;
    cfgWord[RX_THR_LSB +: CNT_W] = thrRxQ;
    statusWord = '0;
    statusWord[STAT_W-1:0] = statusQ;
    enableWord = '0;
    enableWord[STAT_W-1:0] = enableQ;
    countWord = '0;
    countWord[0 +: CNT_W]     = txFree;
    countWord[CNT_W +: CNT_W] = rxLevel;
  end
endmodule

// File: rtl/fifo_evt_irq.sv
module fifo_evt_irq
  import fifo_evt_irq_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int FIFO_DEPTH = 15,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  txLevel,
  input  logic [CNT_W-1:0]  rxLevel,
  input  logic              txUnderrun,
  input  logic              txOverrun,
  input  logic              txFault,
  input  logic              rxUnderrun,
  input  logic              rxOverrun,
  input  logic              rxFault,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq
);
  regStrobe_t        stb;
  logic [DATA_W-1:0] cfgWord, statusWord, enableWord, countWord;

  fifo_evt_irq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .regAddr(regAddr), .regWrEn(regWrEn),
    .cfgWord(cfgWord), .statusWord(statusWord),
    .enableWord(enableWord), .countWord(countWord),
    .stb(stb), .regRdData(regRdData)
  );

  fifo_evt_irq_dp #(.CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .txLevel(txLevel), .rxLevel(rxLevel),
    .txUnderrun(txUnderrun), .txOverrun(txOverrun), .txFault(txFault),
    .rxUnderrun(rxUnderrun), .rxOverrun(rxOverrun), .rxFault(rxFault),
    .stb(stb), .wrData(regWrData),
    .cfgWord(cfgWord), .statusWord(statusWord),
    .enableWord(enableWord), .countWord(countWord), .irq(irq)
  );
endmodule

// File: rtl/fifo_evt_irq_chk.sv
module fifo_evt_irq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              txUnderrun,
  input logic              txFault,
  input logic              rxOverrun,
  input logic [1:0]        regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] statusWord,
  input logic [DATA_W-1:0] enableWord,
  input logic              irq
);
  logic statWr;
  assign statWr = regWrEn && (regAddr == 2'd1);

  p_tx_fault_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    txFault |=> statusWord[3]);

  p_rx_overrun_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun |=> statusWord[6]);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    !statWr |=> ((statusWord & $past(statusWord)) == $past(statusWord)));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && regWrData[3] && !txFault) |=> !statusWord[3]);

  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && regWrData[1] && txUnderrun) |=> statusWord[1]);

  p_irq_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (enableWord == '0) |-> !irq);
endmodule

bind fifo_evt_irq fifo_evt_irq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .txUnderrun(txUnderrun), .txFault(txFault),
  .rxOverrun(rxOverrun), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .statusWord(statusWord), .enableWord(enableWord),
  .irq(irq)
);

// File: tb/fifo_evt_irq_tb.sv
module fifo_evt_irq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  txLevel = '0, rxLevel = '0;
  logic        txUnderrun = 0, txOverrun = 0, txFault = 0;
  logic        rxUnderrun = 0, rxOverrun = 0, rxFault = 0;
  logic [1:0]  regAddr = '0;
  logic        regWrEn = 0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  fifo_evt_irq u_dut (
    .clk(clk), .rstN(rstN), .txLevel(txLevel), .rxLevel(rxLevel),
    .txUnderrun(txUnderrun), .txOverrun(txOverrun), .txFault(txFault),
    .rxUnderrun(rxUnderrun), .rxOverrun(rxOverrun), .rxFault(rxFault),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk);
    regWrEn = 0; regWrData = '0;
  endtask

  task automatic clearAll();
    wr(2'd1, 16'h00FF);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] d;
    logic [7:0]  exp8;
    idle(2);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); check("R1 cfg", d, 16'h4040);
    rd(2'd1, d); check("R1 status", d, 16'h0000);
    rd(2'd2, d); check("R1 enable", d, 16'h0000);
    check("R1 irq", {15'b0, irq}, 16'h0);

    // R2/R3 each strobe alone, sticky after release
    for (int k = 0; k < 6; k++) begin
      txUnderrun = (k == 0); txOverrun = (k == 1); txFault = (k == 2);
      rxUnderrun = (k == 3); rxOverrun = (k == 4); rxFault = (k == 5);
      @(negedge clk);
      {txUnderrun, txOverrun, txFault, rxUnderrun, rxOverrun, rxFault} = '0;
      exp8 = (k < 3) ? 8'(1 << (k + 1)) : 8'(1 << (k + 2));
      rd(2'd1, d); check(k < 3 ? "R2 set" : "R3 set", d, {8'h0, exp8});
      idle(2);
      rd(2'd1, d); check(k < 3 ? "R2 sticky" : "R3 sticky", d, {8'h0, exp8});
      clearAll();
      rd(2'd1, d); check("R6 clear all", d, 16'h0);
    end

    // R6 partial clear
    {txUnderrun, txOverrun, txFault, rxUnderrun, rxOverrun, rxFault} = '1;
    @(negedge clk);
    {txUnderrun, txOverrun, txFault, rxUnderrun, rxOverrun, rxFault} = '0;
    wr(2'd1, 16'hFF24);
    rd(2'd1, d); check("R6 partial", d, 16'h00CA);
    // R8 sweep all enable values against status 0xCA
    for (int e = 0; e < 256; e++) begin
      wr(2'd2, 16'(e));
      rd(2'd2, d); check("R8 enable readback", d, 16'(e));
      check("R8 irq", {15'b0, irq}, {15'b0, |(8'hCA & 8'(e))});
    end
    wr(2'd2, 16'h0000);
    check("R8 disable", {15'b0, irq}, 16'h0);
    clearAll();

    // R7 event beats clear
    txUnderrun = 1; rxFault = 1;
    wr(2'd1, 16'h00FF);
    txUnderrun = 0; rxFault = 0;
    rd(2'd1, d); check("R7 event wins", d, 16'h0082);
    clearAll();

    // R9 configuration field placement
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d); check("R9 cfg mask", d, 16'hF0F0);
    wr(2'd0, 16'h3A5C);
    rd(2'd0, d); check("R9 cfg fields", d, 16'h3050);

    // R4 tx below-threshold crossing sweep
    for (int t = 0; t < 16; t++) begin
      for (int l = 0; l < 16; l++) begin
        wr(2'd0, 16'(t << 4));
        txLevel = 4'd15;
        @(negedge clk);
        clearAll();
        txLevel = 4'(l);
        @(negedge clk);
        rd(2'd1, d); check("R4 crossing", d, {15'b0, l < t});
        clearAll();
        idle(1);
        rd(2'd1, d); check("R4 once", d, 16'h0);
      end
    end
    txLevel = 4'd15;

    // R5 rx at-threshold crossing sweep
    for (int t = 0; t < 16; t++) begin
      for (int l = 0; l < 16; l++) begin
        wr(2'd0, 16'(t << 12));
        rxLevel = 4'd0;
        @(negedge clk);
        clearAll();
        rxLevel = 4'(l);
        @(negedge clk);
        rd(2'd1, d); check("R5 crossing", d, ((l >= t) && (t > 0)) ? 16'h0010 : 16'h0);
        clearAll();
        idle(1);
        rd(2'd1, d); check("R5 once", d, 16'h0);
      end
    end

    // R10 count word sweep and write ignored
    for (int l = 0; l < 16; l++) begin
      txLevel = 4'(l); rxLevel = 4'(15 - l);
      rd(2'd3, d);
      check("R10 counts", d, {8'h0, 4'(15 - l), (l >= 15) ? 4'd0 : 4'(15 - l)});
    end
    wr(2'd0, 16'h4040);
    wr(2'd2, 16'h0000);
    clearAll();
    wr(2'd3, 16'hFFFF);
    rd(2'd0, d); check("R10 write ignored cfg", d, 16'h4040);
    rd(2'd1, d); check("R10 write ignored status", d, 16'h0000);
    rd(2'd2, d); check("R10 write ignored enable", d, 16'h0000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule